// File: doc/BRIEF.md
# Misaligned Access Bus Splitter

This block sits between a load/store requester and a word-wide memory bus. The requester presents a byte address, an access size of one, two or four bytes, a read/write flag and right-justified write data. The bus side only sees word addresses and a set of byte-lane enables. An access whose bytes fall inside one word becomes a single bus cycle. An access that runs past the end of a word is handled by a static policy: it can be broken into two consecutive word cycles whose lanes are merged into one result, it can be refused with an alignment fault and no bus traffic, or its low address bits can be cleared so that it becomes the aligned access at or below the requested address.

Byte order is selectable. In little-endian order the least significant byte of the value sits at the lowest address; in big-endian order the most significant byte does. Each request gets exactly one response pulse. A busy indication covers both cycles of a split access so that a bus arbiter can keep the pair atomic.

Top module: `mis_split_top`

## Requirements
- R1: The bus address is the byte address with its two low bits dropped (bits 31..2); bus lane l (data bits 8l+7..8l, enable bit l) carries the byte at offset l of the addressed word.
- R2: Every bus cycle has a non-zero, contiguous set of lane enables.
- R3: A one-byte access (size code 0) is never split and never faults under any policy; it takes exactly one bus cycle.
- R4: With policy code 0 (split), an access whose bytes cross a word boundary takes two cycles, word W then W+1; a four-byte access at 0x100D uses word 0x403 with enables 4'b1110 and then word 0x404 with enables 4'b0001.
- R5: A two-byte access at byte offset 3 under the split policy enables lane 3 only in the first cycle and lane 0 only in the second; at offset 1 it is a single cycle with enables 4'b0110.
- R6: With policy code 1 (trap), a multi-byte access whose address is not a multiple of its size produces a response with rsp_fault_o high and rsp_rdata_o zero in the cycle after acceptance, and starts no bus cycle.
- R7: With policy code 2 (round-down), the low log2(size) address bits are cleared and the access completes in one aligned cycle without a fault.
- R8: With big_endian_i low, value byte i (bits 8i+7..8i) goes to address+i; with it high, value byte i goes to address+n-1-i for an n-byte access. A four-byte write of 0x0AC0FFEE at 0x1000 drives bus data 0x0AC0FFEE in little-endian order and 0xEEFFC00A in big-endian order.
- R9: Read data is returned right-justified with unused upper bytes zero, on a single rsp_valid_o pulse in the cycle after the last bus handshake; a write also gets one pulse, with zero data.
- R10: split_busy_o is high from the first cycle of a split access until its second cycle completes, and stays low during single-cycle accesses.
- R11: req_ready_o is high only while no bus cycle is pending; address, size, data, policy and byte order are sampled at acceptance, and changing them afterwards has no effect on that access.
- R12: While bus_valid_o is high and bus_ready_i low, bus address, enables and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| policy_i | input | 2 | Crossing policy: 0 split, 1 trap, 2 round-down (3 acts as split) |
| big_endian_i | input | 1 | Byte order select, 1 = big-endian |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted when high with req_valid_i |
| req_addr_i | input | 32 | Byte address |
| req_size_i | input | 2 | Size code: 0 one byte, 1 two bytes, 2 four bytes (3 treated as 2) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | 32 | Right-justified write value |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_fault_o | output | 1 | Alignment fault, valid with rsp_valid_o |
| rsp_rdata_o | output | 32 | Right-justified read value |
| bus_valid_o | output | 1 | Bus cycle requested |
| bus_ready_i | input | 1 | Bus cycle completes this clock |
| bus_addr_o | output | 30 | Word address |
| bus_write_o | output | 1 | Bus cycle direction |
| bus_be_o | output | 4 | Byte-lane enables |
| bus_wdata_o | output | 32 | Lane-placed write data |
| bus_rdata_i | input | 32 | Read data, valid with bus_ready_i |
| split_busy_o | output | 1 | Split access in progress |

## Verification
Every combination of policy, byte order and size is applied at all eight byte offsets across two adjacent words, as both a read and a write, against a bench memory with distinct byte values. Offsets 0 to 3 separate aligned from misaligned but word-internal accesses, while offsets that run past a word boundary tell the split, trap and round-down policies apart by cycle count, lane enables and fault. Reads compare merged values against a bench-side byte model in both orders; writes compare the whole memory, so stray lanes show up. Bus stalls are inserted on alternate offsets to expose cycles that change while waiting, and inputs are scrambled right after acceptance to show they are sampled only once.

// File: rtl/mis_split_pkg.sv
package mis_split_pkg;

  typedef enum logic [1:0] {
    POL_SPLIT = 2'd0,
    POL_TRAP  = 2'd1,
    POL_ROUND = 2'd2
  } policy_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS0 = 2'd1,
    ST_BUS1 = 2'd2
  } state_e;

endpackage

// File: rtl/mis_split_planner.sv
module mis_split_planner #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4,
  parameter int OFS_W  = $clog2(LANES),
  parameter int SZ_W   = $clog2(OFS_W + 1),
  parameter int WA_W   = ADDR_W - OFS_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SZ_W-1:0]   size_i,
  input  logic [1:0]        policy_i,
  output logic [WA_W-1:0]   word_o,
  output logic [OFS_W-1:0]  off_o,
  output logic [SZ_W-1:0]   nlog_o,
  output logic [LANES-1:0]  be0_o,
  output logic [LANES-1:0]  be1_o,
  output logic              cross_o,
  output logic              fault_o
);
  import mis_split_pkg::*;

  localparam int WIN = 2 * LANES;

  logic [SZ_W-1:0]   nlog;
  logic [OFS_W-1:0]  amask;
  logic              misal;
  logic [ADDR_W-1:0] eff;
  logic [WIN-1:0]    win;
  int                nbytes;
  int                base;

  always_comb begin
    nlog = (int'(size_i) > OFS_W) ? SZ_W'(OFS_W) : size_i;
    nbytes = 1 << nlog;
    for (int b = 0; b < OFS_W; b++) amask[b] = (b < int'(nlog));
    misal = |(addr_i[OFS_W-1:0] & amask);
    eff = addr_i;
    if (policy_i == POL_ROUND) eff[OFS_W-1:0] = addr_i[OFS_W-1:0] & ~amask;
    base = int'(eff[OFS_W-1:0]);
    for (int i = 0; i < WIN; i++) win[i] = (i >= base) && (i < base + nbytes);
  end

  assign word_o  = eff[ADDR_W-1:OFS_W];
  assign off_o   = eff[OFS_W-1:0];
  assign nlog_o  = nlog;
  assign be0_o   = win[LANES-1:0];
  assign be1_o   = win[WIN-1:LANES];
  assign cross_o = |win[WIN-1:LANES];
  assign fault_o = (policy_i == POL_TRAP) && misal;

endmodule

// File: rtl/mis_split_wr_steer.sv
module mis_split_wr_steer #(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int OFS_W  = $clog2(LANES),
  parameter int SZ_W   = $clog2(OFS_W + 1)
) (
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [OFS_W-1:0]    off_i,
  input  logic [SZ_W-1:0]     nlog_i,
  input  logic                big_i,
  output logic [2*DATA_W-1:0] win_o
);
  int n;
  int src;

  always_comb begin
    win_o = '0;
    n = 1 << nlog_i;
    src = 0;
    for (int k = 0; k < LANES; k++) begin
      if (k < n) begin
        src = big_i ? (n - 1 - k) : k;
        win_o[(int'(off_i) + k)*8 +: 8] = wdata_i[src*8 +: 8];
      end
    end
  end

endmodule

// File: rtl/mis_split_rd_merge.sv
module mis_split_rd_merge #(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int OFS_W  = $clog2(LANES),
  parameter int SZ_W   = $clog2(OFS_W + 1)
) (
  input  logic [2*DATA_W-1:0] win_i,
  input  logic [OFS_W-1:0]    off_i,
  input  logic [SZ_W-1:0]     nlog_i,
  input  logic                big_i,
  output logic [DATA_W-1:0]   value_o
);
  int n;
  int dst;

  always_comb begin
    value_o = '0;
    n = 1 << nlog_i;
    dst = 0;
    for (int k = 0; k < LANES; k++) begin
      if (k < n) begin
        dst = big_i ? (n - 1 - k) : k;
        value_o[dst*8 +: 8] = win_i[(int'(off_i) + k)*8 +: 8];
      end
    end
  end

endmodule

// File: rtl/mis_split_top.sv
module mis_split_top #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFS_W = $clog2(LANES),
  localparam int SZ_W  = $clog2(OFS_W + 1),
  localparam int WA_W  = ADDR_W - OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        policy_i,
  input  logic              big_endian_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [SZ_W-1:0]   req_size_i,
  input  logic              req_write_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic              rsp_fault_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              bus_valid_o,
  input  logic              bus_ready_i,
  output logic [WA_W-1:0]   bus_addr_o,
  output logic              bus_write_o,
  output logic [LANES-1:0]  bus_be_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              split_busy_o
);
  import mis_split_pkg::*;

  state_e state_q;

  logic [WA_W-1:0]  p_word;
  logic [OFS_W-1:0] p_off;
  logic [SZ_W-1:0]  p_nlog;
  logic [LANES-1:0] p_be0, p_be1;
  logic             p_cross, p_fault;
  logic [2*DATA_W-1:0] p_wwin;

  logic [WA_W-1:0]     lat_word;
  logic [OFS_W-1:0]    lat_off;
  logic [SZ_W-1:0]     lat_nlog;
  logic [LANES-1:0]    lat_be0, lat_be1;
  logic                lat_cross, lat_write, lat_big;
  logic [2*DATA_W-1:0] lat_wwin;
  logic [DATA_W-1:0]   rbuf_lo;

  logic [2*DATA_W-1:0] rd_win;
  logic [DATA_W-1:0]   merged;

  logic              rsp_valid_q, rsp_fault_q;
  logic [DATA_W-1:0] rsp_rdata_q;

  mis_split_planner #(
    .ADDR_W(ADDR_W), .LANES(LANES), .OFS_W(OFS_W), .SZ_W(SZ_W), .WA_W(WA_W)
  ) i_planner (
    .addr_i  (req_addr_i),
    .size_i  (req_size_i),
    .policy_i(policy_i),
    .word_o  (p_word),
    .off_o   (p_off),
    .nlog_o  (p_nlog),
    .be0_o   (p_be0),
    .be1_o   (p_be1),
    .cross_o (p_cross),
    .fault_o (p_fault)
  );

  mis_split_wr_steer #(
    .DATA_W(DATA_W), .LANES(LANES), .OFS_W(OFS_W), .SZ_W(SZ_W)
  ) i_wr_steer (
    .wdata_i(req_wdata_i),
    .off_i  (p_off),
    .nlog_i (p_nlog),
    .big_i  (big_endian_i),
    .win_o  (p_wwin)
  );

  // second half in upper word, first half from buffer
  assign rd_win = (state_q == ST_BUS1) ? {bus_rdata_i, rbuf_lo} : {{DATA_W{1'b0}}, bus_rdata_i};

  mis_split_rd_merge #(
    .DATA_W(DATA_W), .LANES(LANES), .OFS_W(OFS_W), .SZ_W(SZ_W)
  ) i_rd_merge (
    .win_i  (rd_win),
    .off_i  (lat_off),
    .nlog_i (lat_nlog),
    .big_i  (lat_big),
    .value_o(merged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      lat_word    <= '0;
      lat_off     <= '0;
      lat_nlog    <= '0;
      lat_be0     <= '0;
      lat_be1     <= '0;
      lat_cross   <= 1'b0;
      lat_write   <= 1'b0;
      lat_big     <= 1'b0;
      lat_wwin    <= '0;
      rbuf_lo     <= '0;
      rsp_valid_q <= 1'b0;
      rsp_fault_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      rsp_fault_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            if (p_fault) begin
              rsp_valid_q <= 1'b1;
              rsp_fault_q <= 1'b1;
              rsp_rdata_q <= '0;
            end else begin
              lat_word  <= p_word;
              lat_off   <= p_off;
              lat_nlog  <= p_nlog;
              lat_be0   <= p_be0;
              lat_be1   <= p_be1;
              lat_cross <= p_cross;
              lat_write <= req_write_i;
              lat_big   <= big_endian_i;
              lat_wwin  <= p_wwin;
              state_q   <= ST_BUS0;
            end
          end
        end
        ST_BUS0: begin
          if (bus_ready_i) begin
            rbuf_lo <= bus_rdata_i;
            if (lat_cross) begin
              state_q <= ST_BUS1;
            end else begin
              state_q     <= ST_IDLE;
              rsp_valid_q <= 1'b1;
              rsp_rdata_q <= lat_write ? '0 : merged;
            end
          end
        end
        ST_BUS1: begin
          if (bus_ready_i) begin
            state_q     <= ST_IDLE;
            rsp_valid_q <= 1'b1;
            rsp_rdata_q <= lat_write ? '0 : merged;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o  = (state_q == ST_IDLE);
  assign bus_valid_o  = (state_q == ST_BUS0) || (state_q == ST_BUS1);
  assign bus_addr_o   = (state_q == ST_BUS1) ? lat_word + 1'b1 : lat_word;
  assign bus_be_o     = (state_q == ST_BUS1) ? lat_be1 : lat_be0;
  assign bus_wdata_o  = (state_q == ST_BUS1) ? lat_wwin[2*DATA_W-1:DATA_W] : lat_wwin[DATA_W-1:0];
  assign bus_write_o  = lat_write;
  assign split_busy_o = ((state_q == ST_BUS0) && lat_cross) || (state_q == ST_BUS1);
  assign rsp_valid_o  = rsp_valid_q;
  assign rsp_fault_o  = rsp_fault_q;
  assign rsp_rdata_o  = rsp_rdata_q;

  assert_be_contig_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o |-> (bus_be_o != '0) &&
      (((bus_be_o + (bus_be_o & (~bus_be_o + 1'b1))) & bus_be_o) == '0));

  assert_byte_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_size_i == '0) |=> !split_busy_o && !rsp_fault_o);

  assert_split_next_word_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BUS0 && lat_cross && bus_ready_i) |=>
      bus_valid_o && split_busy_o && (bus_addr_o == $past(bus_addr_o) + 1'b1));

  assert_trap_no_bus_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && p_fault) |=> rsp_valid_o && rsp_fault_o && !bus_valid_o);

  assert_single_rsp_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && bus_ready_i && !split_busy_o) |=> rsp_valid_o && !rsp_fault_o);

  assert_busy_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (split_busy_o && !bus_ready_i) |=> split_busy_o);

  assert_ready_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !bus_valid_o);

  assert_bus_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && !bus_ready_i) |=> bus_valid_o && $stable(bus_addr_o) &&
      $stable(bus_be_o) && $stable(bus_wdata_o));

endmodule

// File: tb/test_mis_split_top.sv
`timescale 1ns/1ps
module test_mis_split_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  policy = 2'd0;
  logic        big = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_fault;
  logic [31:0] rsp_rdata;
  logic        bus_valid, bus_ready, bus_write, split_busy;
  logic [29:0] bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata, bus_rdata;

  always #2.5 clk = ~clk;

  mis_split_top i_mis_split_top (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(policy), .big_endian_i(big),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .req_size_i(req_size), .req_write_i(req_write), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault), .rsp_rdata_o(rsp_rdata),
    .bus_valid_o(bus_valid), .bus_ready_i(bus_ready), .bus_addr_o(bus_addr),
    .bus_write_o(bus_write), .bus_be_o(bus_be), .bus_wdata_o(bus_wdata),
    .bus_rdata_i(bus_rdata), .split_busy_o(split_busy)
  );

  // bus slave: 64-byte memory, optional alternate-cycle stall
  logic [7:0]  mem  [64];
  logic [7:0]  refm [64];
  logic        stall_en = 1'b0;
  logic        stall_ph = 1'b0;
  int          hs_total = 0;
  logic [29:0] log_addr [4];
  logic [3:0]  log_be   [4];
  logic [31:0] log_wd   [4];
  logic        log_busy [4];
  int          hold_viol = 0;
  int          ready_viol = 0;
  int          busy_single = 0;
  logic        was_stalled = 1'b0;
  logic [29:0] st_addr;
  logic [3:0]  st_be;
  logic [31:0] st_wd;

  assign bus_ready = bus_valid && !(stall_en && stall_ph);
  always_comb begin
    for (int l = 0; l < 4; l++) bus_rdata[l*8 +: 8] = mem[{bus_addr[3:0], 2'(l)}];
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i]  = 8'(i * 37 + 5);
      refm[i] = 8'(i * 37 + 5);
    end
  end

  always @(posedge clk) begin
    if (rst_n) begin
      stall_ph <= ~stall_ph;
      if (req_ready && bus_valid) ready_viol <= ready_viol + 1;
      if (was_stalled && !(bus_valid && bus_addr == st_addr && bus_be == st_be && bus_wdata == st_wd))
        hold_viol <= hold_viol + 1;
      was_stalled <= bus_valid && !bus_ready;
      st_addr <= bus_addr; st_be <= bus_be; st_wd <= bus_wdata;
      if (bus_valid && bus_ready) begin
        log_addr[hs_total % 4] <= bus_addr;
        log_be[hs_total % 4]   <= bus_be;
        log_wd[hs_total % 4]   <= bus_wdata;
        log_busy[hs_total % 4] <= split_busy;
        hs_total <= hs_total + 1;
        if (bus_write)
          for (int l = 0; l < 4; l++)
            if (bus_be[l]) mem[{bus_addr[3:0], 2'(l)}] <= bus_wdata[l*8 +: 8];
      end
    end
  end

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // runs one request and checks it against an arithmetic model
  task automatic run_req(input logic [31:0] a, input int sz, input bit wr, input logic [31:0] wd,
                         input int pol, input bit be_big, input bit stall);
    int n, o, base, cyc, t;
    bit exp_fault;
    logic [31:0] eff, exp_val;
    logic [7:0] m;
    bit mem_ok;
    n = 1 << sz;
    exp_fault = (pol == 1) && ((a % n) != 0);
    eff = (pol == 2) ? (a & ~32'(n - 1)) : a;
    o = int'(eff % 4);
    m = 8'(((1 << n) - 1) << o);
    exp_val = '0;
    for (int j = 0; j < n; j++)
      exp_val[j*8 +: 8] = be_big ? refm[(eff + 32'(n - 1 - j)) % 64] : refm[(eff + 32'(j)) % 64];
    @(negedge clk);
    stall_en = stall;
    req_addr = a; req_size = 2'(sz); req_write = wr; req_wdata = wd;
    policy = 2'(pol); big = be_big; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    base = hs_total;
    @(negedge clk);
    req_valid = 1'b0;
    // scramble after acceptance (R11)
    req_addr = ~a; req_size = 2'(sz + 1); req_wdata = ~wd; req_write = ~wr;
    policy = 2'(pol + 1); big = ~be_big;
    t = 0;
    while (!rsp_valid && t < 50) begin @(negedge clk); t++; end
    chk(rsp_valid, "R9 response pulse", 32'(rsp_valid), 1);
    chk(rsp_fault == exp_fault, "R6/R3 fault flag", 32'(rsp_fault), 32'(exp_fault));
    cyc = hs_total - base;
    if (exp_fault) begin
      chk(cyc == 0, "R6 no bus cycle on trap", 32'(cyc), 0);
      chk(rsp_rdata == 0, "R6 fault data zero", rsp_rdata, 0);
    end else begin
      chk(cyc == ((o + n > 4) ? 2 : 1), "R3/R4/R7 cycle count R11", 32'(cyc), 32'((o + n > 4) ? 2 : 1));
      chk(log_addr[base % 4] == eff[31:2], "R1/R7 first word", 32'(log_addr[base % 4]), 32'(eff[31:2]));
      chk(log_be[base % 4] == m[3:0], "R1/R5 first enables", 32'(log_be[base % 4]), 32'(m[3:0]));
      chk(log_busy[base % 4] == (o + n > 4), "R10 busy in first cycle", 32'(log_busy[base % 4]), 32'(o + n > 4));
      if (o + n > 4) begin
        chk(log_addr[(base + 1) % 4] == eff[31:2] + 1, "R4 second word", 32'(log_addr[(base + 1) % 4]), 32'(eff[31:2] + 1));
        chk(log_be[(base + 1) % 4] == m[7:4], "R4/R5 second enables", 32'(log_be[(base + 1) % 4]), 32'(m[7:4]));
        chk(log_busy[(base + 1) % 4], "R10 busy in second cycle", 32'(log_busy[(base + 1) % 4]), 1);
      end
      if (wr) begin
        for (int k = 0; k < n; k++)
          refm[(eff + 32'(k)) % 64] = be_big ? wd[(n - 1 - k)*8 +: 8] : wd[k*8 +: 8];
        mem_ok = 1'b1;
        for (int i = 0; i < 64; i++) if (mem[i] !== refm[i]) mem_ok = 1'b0;
        chk(mem_ok, "R8 memory image after write", 32'(mem_ok), 1);
        chk(rsp_rdata == 0, "R9 write response data", rsp_rdata, 0);
      end else begin
        chk(rsp_rdata == exp_val, "R8/R9 merged read", rsp_rdata, exp_val);
      end
    end
    @(negedge clk);
    chk(!rsp_valid, "R9 single pulse", 32'(rsp_valid), 0);
  endtask

  initial begin
    int it;
    #12;
    @(negedge clk);
    chk(req_ready == 1'b1, "R11 reset ready", 32'(req_ready), 1);
    chk(!bus_valid && !rsp_valid && !split_busy, "R10 reset idle",
        {29'd0, bus_valid, rsp_valid, split_busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // value 0x0AC0FFEE at 0x1000 in both orders (R8)
    run_req(32'h1000, 2, 1'b1, 32'h0AC0FFEE, 0, 1'b0, 1'b0);
    chk(log_wd[(hs_total - 1) % 4] == 32'h0AC0FFEE, "R8 little-endian lanes", log_wd[(hs_total - 1) % 4], 32'h0AC0FFEE);
    run_req(32'h1000, 2, 1'b1, 32'h0AC0FFEE, 0, 1'b1, 1'b0);
    chk(log_wd[(hs_total - 1) % 4] == 32'hEEFFC00A, "R8 big-endian lanes", log_wd[(hs_total - 1) % 4], 32'hEEFFC00A);
    // 4 bytes at 0x100D: 0x403 then 0x404 (R4)
    run_req(32'h100D, 2, 1'b0, 32'h0, 0, 1'b0, 1'b1);
    chk(log_addr[(hs_total - 2) % 4] == 30'h403 && log_addr[(hs_total - 1) % 4] == 30'h404,
        "R4 split at 0x100D", 32'(log_addr[(hs_total - 1) % 4]), 32'h404);

    it = 0;
    for (int pol = 0; pol < 3; pol++)
      for (int bg = 0; bg < 2; bg++)
        for (int sz = 0; sz < 3; sz++)
          for (int off = 0; off < 8; off++)
            for (int wr = 0; wr < 2; wr++) begin
              it++;
              run_req(32'h1008 + 32'(off), sz, wr[0], 32'h9E3779B9 * 32'(it), pol, bg[0], off[0]);
            end

    chk(hold_viol == 0, "R12 stable while stalled", 32'(hold_viol), 0);
    chk(ready_viol == 0, "R11 ready only when idle", 32'(ready_viol), 0);
    chk(busy_single == 0, "R10 no busy on single", 32'(busy_single), 0);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule